// File: doc/BRIEF.md
# Two's-Complement Add/Subtract Unit with Condition Flags

This block adds or subtracts two signed operands of parameterised width and reports three condition flags next to the result. A single control input picks the operation. The datapath is one ripple chain of one-bit full adders. For subtraction, the second operand is bitwise inverted and a carry of one is injected at the least significant stage. This gives the two's-complement difference without a second adder.

The flags are a zero indicator, a signed overflow indicator and a negative indicator. They are meant to feed a later comparison stage. The overflow indicator is formed from the sign bits of the first operand, the conditioned second operand and the result. It does not use the carry chain.

The unit is purely combinational. There is no clock and no reset, and every output follows the inputs once the logic has settled.

Top module: `aru_addsub`

## Requirements
- R1: With `sub_en` = 0, `result` equals `opa + opb` modulo 2^WIDTH.
- R2: With `sub_en` = 1, `result` equals `opa - opb` modulo 2^WIDTH.
- R3: `zero_flag` is 1 exactly when every bit of `result` is 0.
- R4: `neg_flag` equals bit WIDTH-1 of `result`.
- R5: `ovf_flag` is 1 exactly when the true signed sum or difference lies outside the range -2^(WIDTH-1) to 2^(WIDTH-1)-1.
- R6: `ovf_flag` is 0 whenever the effective operands have opposite signs. This covers an add with `opa` and `opb` of different sign bits, and a subtract with `opa` and `opb` of equal sign bits.
- R7: With WIDTH = 32, `0 - 0x80000000` gives `result` 0x80000000 with `ovf_flag` = 1. `0x7FFFFFFF + 1` gives 0x80000000 with `ovf_flag` = 1 and `neg_flag` = 1.
- R8: A subtract with `opa` equal to `opb` gives `result` 0 with `zero_flag` = 1, `neg_flag` = 0 and `ovf_flag` = 0.
- R9: The behaviour of R1 to R5 holds for any WIDTH of 1 or more. All outputs settle from the inputs alone, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First signed operand |
| opb | input | WIDTH | Second signed operand |
| sub_en | input | 1 | 0 selects add, 1 selects subtract |
| result | output | WIDTH | Sum or difference |
| zero_flag | output | 1 | Result is all zeros |
| ovf_flag | output | 1 | Signed overflow occurred |
| neg_flag | output | 1 | Sign bit of the result |

## Verification
The bench builds two copies of the unit. The first is 32 bits wide and is driven with seeded random operands biased toward the extreme signed values, equal pairs and small values, plus the directed overflow corners. The second is 4 bits wide and is swept over every operand pair in both modes. That sweep reaches every overflow boundary, every zero result and every sign combination, which random 32-bit stimulus would almost never hit. It also shows that the ripple chain and its sum-only top stage work at a width other than the default.

// File: rtl/aru_pkg.sv
package aru_pkg;

    typedef enum logic {
        ARU_ADD = 1'b0,
        ARU_SUB = 1'b1
    } aru_op_e;

    typedef struct packed {
        logic zero;
        logic ovf;
        logic neg;
    } aru_flags_t;

endpackage

// File: rtl/aru_full_add.sv
module aru_full_add (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    logic half_d;

    always_comb begin
        half_d = a ^ b;
        s      = half_d ^ ci;
        co     = (a & b) | (ci & half_d);
    end
endmodule

// File: rtl/aru_operand_cond.sv
module aru_operand_cond
    import aru_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] b_i,
    input  aru_op_e          op_i,
    output logic [WIDTH-1:0] xb_o,
    output logic             cin_o
);
    logic inv_d;

    always_comb begin
        inv_d = (op_i == ARU_SUB);
        xb_o  = b_i ^ {WIDTH{inv_d}};
        cin_o = inv_d;
    end
endmodule

// File: rtl/aru_ripple_chain.sv
module aru_ripple_chain #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o
);
    // carry_d[i] is the carry entering stage i
    logic [WIDTH-1:0] carry_d;

    assign carry_d[0] = cin_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i < WIDTH - 1) begin : g_full
            aru_full_add u_fa (
                .a  (a_i[i]),
                .b  (b_i[i]),
                .ci (carry_d[i]),
                .s  (sum_o[i]),
                .co (carry_d[i+1])
            );
        end else begin : g_top
            // top stage: no carry-out is consumed, so only the sum is built
            assign sum_o[i] = a_i[i] ^ b_i[i] ^ carry_d[i];
        end
    end

    // R1 / R2: chain output matches modular sum of its inputs
    always_comb begin
        a_r1_chain_sum: assert (sum_o == a_i + b_i + WIDTH'(cin_i));
    end
endmodule

// File: rtl/aru_flag_gen.sv
module aru_flag_gen
    import aru_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             a_msb_i,
    input  logic             xb_msb_i,
    input  logic [WIDTH-1:0] sum_i,
    output aru_flags_t       flags_o
);
    logic s_msb_d;

    always_comb begin
        s_msb_d      = sum_i[WIDTH-1];
        flags_o.zero = ~|sum_i;
        flags_o.neg  = s_msb_d;
        flags_o.ovf  = (a_msb_i & xb_msb_i & ~s_msb_d) |
                       (~a_msb_i & ~xb_msb_i & s_msb_d);
    end
endmodule

// File: rtl/aru_addsub.sv
module aru_addsub
    import aru_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             sub_en,
    output logic [WIDTH-1:0] result,
    output logic             zero_flag,
    output logic             ovf_flag,
    output logic             neg_flag
);
    localparam int MSB = WIDTH - 1;

    aru_op_e          op_d;
    logic [WIDTH-1:0] xb_d;
    logic             cin_d;
    logic [WIDTH-1:0] sum_d;
    aru_flags_t       flags_d;

    assign op_d = aru_op_e'(sub_en);

    aru_operand_cond #(.WIDTH(WIDTH)) u_cond (
        .b_i   (opb),
        .op_i  (op_d),
        .xb_o  (xb_d),
        .cin_o (cin_d)
    );

    aru_ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .a_i   (opa),
        .b_i   (xb_d),
        .cin_i (cin_d),
        .sum_o (sum_d)
    );

    aru_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .a_msb_i  (opa[MSB]),
        .xb_msb_i (xb_d[MSB]),
        .sum_i    (sum_d),
        .flags_o  (flags_d)
    );

    always_comb begin
        result    = sum_d;
        zero_flag = flags_d.zero;
        ovf_flag  = flags_d.ovf;
        neg_flag  = flags_d.neg;
    end

    // Checks relating the ports to an independent wide signed model
    logic signed [WIDTH:0] wide_d;
    logic                  ovf_ref_d;

    always_comb begin
        if (sub_en)
            wide_d = $signed({opa[MSB], opa}) - $signed({opb[MSB], opb});
        else
            wide_d = $signed({opa[MSB], opa}) + $signed({opb[MSB], opb});
        ovf_ref_d = wide_d[WIDTH] ^ wide_d[MSB];

        if (!sub_en) begin
            a_r1_add_result: assert (result == opa + opb);
        end
        if (sub_en) begin
            a_r2_sub_result: assert (result == opa - opb);
        end
        a_r5_overflow: assert (ovf_flag == ovf_ref_d);
        if ((opa[MSB] ^ opb[MSB]) != sub_en) begin
            a_r6_no_overflow: assert (!ovf_flag);
        end
        if (sub_en && (opa == opb)) begin
            a_r8_self_sub: assert (zero_flag && !ovf_flag && !neg_flag);
        end
    end
endmodule

// File: tb/sim_aru_addsub.sv
module sim_aru_addsub;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] a0, b0, r0;
    logic        s0, z0, v0, n0;
    logic [3:0]  a1, b1, r1;
    logic        s1, z1, v1, n1;

    aru_addsub u0 (
        .opa(a0), .opb(b0), .sub_en(s0),
        .result(r0), .zero_flag(z0), .ovf_flag(v0), .neg_flag(n0)
    );

    aru_addsub #(.WIDTH(4)) u1 (
        .opa(a1), .opb(b1), .sub_en(s1),
        .result(r1), .zero_flag(z1), .ovf_flag(v1), .neg_flag(n1)
    );

    function automatic logic [31:0] exp_res(logic [31:0] a, logic [31:0] b, logic s);
        return s ? (a - b) : (a + b);
    endfunction

    function automatic logic exp_ovf(logic [31:0] a, logic [31:0] b, logic s);
        logic signed [32:0] w;
        w = s ? ($signed({a[31], a}) - $signed({b[31], b}))
              : ($signed({a[31], a}) + $signed({b[31], b}));
        return w[32] ^ w[31];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic drive32(logic [31:0] a, logic [31:0] b, logic s);
        logic [31:0] er;
        @(posedge clk);
        a0 = a; b0 = b; s0 = s;
        @(negedge clk);
        er = exp_res(a, b, s);
        chk(s ? "R2 difference" : "R1 sum", r0, er);
        chk("R3 zero flag", 32'(z0), 32'(er == 32'd0));
        chk("R4 negative flag", 32'(n0), 32'(er[31]));
        chk("R5 overflow flag", 32'(v0), 32'(exp_ovf(a, b, s)));
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 5))
            0: return 32'h7FFF_FFFF - $urandom_range(0, 3);
            1: return 32'h8000_0000 + $urandom_range(0, 3);
            2: return $urandom_range(0, 7);
            3: return 32'hFFFF_FFFF - $urandom_range(0, 7);
            default: return $urandom();
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        a0 = '0; b0 = '0; s0 = 1'b0;
        a1 = '0; b1 = '0; s1 = 1'b0;
        void'($urandom(32'd20241));

        // initial state: all-zero inputs
        @(negedge clk);
        chk("R3 idle zero", 32'(z0), 32'd1);
        chk("R1 idle sum", r0, 32'd0);

        // R7 directed corners
        drive32(32'h0000_0000, 32'h8000_0000, 1'b1);
        chk("R7 0-min ovf", 32'(v0), 32'd1);
        chk("R7 0-min result", r0, 32'h8000_0000);
        drive32(32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
        chk("R7 max+1 result", r0, 32'h8000_0000);
        chk("R7 max+1 ovf", 32'(v0), 32'd1);
        chk("R7 max+1 neg", 32'(n0), 32'd1);
        drive32(32'h8000_0000, 32'h8000_0000, 1'b0);
        drive32(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);

        // R8 equal operands in subtract mode
        for (int k = 0; k < 40; k++) begin
            logic [31:0] x;
            x = pick();
            drive32(x, x, 1'b1);
            chk("R8 self-sub zero", 32'({z0, n0, v0}), 32'b100);
        end

        // R6 opposite effective signs never overflow
        for (int k = 0; k < 200; k++) begin
            logic [31:0] x, y;
            logic s;
            s = 1'($urandom());
            x = pick();
            y = pick();
            y[31] = s ? x[31] : ~x[31];
            drive32(x, y, s);
            chk("R6 no overflow", 32'(v0), 32'd0);
        end

        // R1..R5 biased random
        for (int k = 0; k < 2000; k++) begin
            drive32(pick(), pick(), 1'($urandom()));
        end

        // R9 exhaustive sweep of the 4-bit copy
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    int sa, sb, tr;
                    @(posedge clk);
                    a1 = 4'(a); b1 = 4'(b); s1 = 1'(s);
                    @(negedge clk);
                    sa = (a > 7) ? a - 16 : a;
                    sb = (b > 7) ? b - 16 : b;
                    tr = (s == 1) ? sa - sb : sa + sb;
                    chk("R9 narrow result", 32'(r1), 32'(tr[3:0]));
                    chk("R9 narrow ovf", 32'(v1), 32'((tr > 7) || (tr < -8)));
                    chk("R9 narrow zero", 32'(z1), 32'(tr[3:0] == 4'd0));
                    chk("R9 narrow neg", 32'(n1), 32'(tr[3]));
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule